// File: doc/BRIEF.md
# Line Drive Pulse Activity Monitor

This block watches the transmit side of a line interface for bipolar pulse activity. Each bit period is marked by a single-cycle bit-rate enable. On that enable the block samples the positive and negative pulse indications. A counter runs over bit periods that carry no pulse in either polarity. When it reaches a fixed threshold of 128 periods, the block declares a drive-failure defect. Any single pulse in either polarity clears the defect at once and restarts the count from zero.

The defect is reported to a host through a small register port. A read-only alarm register shows the current defect state. A change-of-condition status bit records every declare and every clear, and a host read of that register clears the bit. An enable register decides whether a pending status bit pulls the active-low interrupt request line low. Reads are combinational on the address. A read strobe is needed only for the clear-on-read side effect, and writes take effect at the clock edge.

Top module: `line_drive_monitor`

## Requirements
- R1: When 128 consecutive bit periods (cycles with `bit_en` high) carry no pulse on `pulse_pos` or `pulse_neg`, the defect is declared at the clock edge that ends the 128th such period. After 127 such periods it is not yet declared.
- R2: Cycles with `bit_en` low neither advance the pulse-free count nor clear the defect, even if the pulse inputs are high in those cycles.
- R3: A bit period with a pulse on `pulse_pos`, `pulse_neg` or both clears a declared defect at that edge. It also restarts the count, so a further 128 pulse-free periods are needed to declare again.
- R4: The pulse-free count saturates at 128. An arbitrarily long silence keeps the defect declared and produces no further change events.
- R5: Address 0 is the read-only alarm register: bit 0 is 1 while the defect is declared and 0 otherwise, bits 7:1 read 0, and writes to it have no effect.
- R6: Every change of the defect state, declare or clear, sets bit 0 of the status register at address 1 at the same edge. Bits 7:1 of that register read 0, and writes to it have no effect.
- R7: A read (`reg_rd` high, address 1) returns the current status value and clears bit 0 at the end of that cycle.
- R8: If a defect change occurs in the same cycle as a status read, the read returns the old value and the status bit is left set.
- R9: Address 2 holds the interrupt enable in bit 0, which can be read and written, with bits 7:1 reading 0. `irq_n` is low exactly when the status bit and the enable bit are both 1. The status bit is still set while the enable is 0.
- R10: After reset the defect is cleared, the count is zero, the status and enable bits are 0, and `irq_n` is high. Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks one bit period of the line clock |
| pulse_pos | input | 1 | Positive bipolar pulse seen in this bit period |
| pulse_neg | input | 1 | Negative bipolar pulse seen in this bit period |
| reg_addr | input | 2 | Register address (0 alarm, 1 status, 2 enable) |
| reg_rd | input | 1 | Read strobe, needed for the clear-on-read side effect |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Silent gaps are swept over every length from 120 to 140 bit periods, plus coarse steps below that. The three pulse polarities are rotated across gaps, which separates an off-by-one threshold from a correct one and shows that each polarity alone clears the defect. Idle cycles are mixed into each gap, which exposes a counter that ignores the bit-rate enable. A silence of 300 periods exposes counter wrap-around. Status reads placed with and without a coincident defect change tell clear-on-read apart from event priority. Enable toggling around a pending event shows that the status bit is recorded independently of the request line.

// File: rtl/ldm_pkg.sv
// Package: shared register map for the line drive pulse activity monitor.
// Assumes a 2-bit register address and an 8-bit data path.
package ldm_pkg;
    localparam int LDM_DATA_W = 8;
    localparam int LDM_ADDR_W = 2;

    typedef enum logic [LDM_ADDR_W-1:0] {
        REG_ALARM   = 2'd0,
        REG_IRQ_STS = 2'd1,
        REG_IRQ_EN  = 2'd2,
        REG_SPARE   = 2'd3
    } ldm_reg_e;
endpackage

// File: rtl/ldm_pulse_timer.sv
// Module: counts pulse-free bit periods and holds the drive-failure defect.
// Assumes bit_en is a one-cycle strobe per bit period; pulses are only
// sampled when bit_en is high. The counter saturates at THRESH.
module ldm_pulse_timer #(
    parameter int THRESH = 128,
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             pulse_any,
    output logic             defect_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             change
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(THRESH - 1);

    logic [CNT_W-1:0] cnt_d;
    logic             defect_d;

    // Next count and next defect state for this bit period.
    always_comb begin
        cnt_d    = cnt_q;
        defect_d = defect_q;
        if (bit_en) begin
            if (pulse_any) begin
                cnt_d    = '0;
                defect_d = 1'b0;
            end else begin
                if (cnt_q != CNT_MAX) begin
                    cnt_d = cnt_q + 1'b1;
                end
                if (cnt_q >= CNT_LAST) begin
                    defect_d = 1'b1;
                end
            end
        end
    end

    // A change event is any difference between next and current defect.
    assign change = (defect_d != defect_q);

    // Register count and defect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            defect_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            defect_q <= defect_d;
        end
    end
endmodule

// File: rtl/ldm_irq_ctrl.sv
// Module: change-of-condition status bit, interrupt enable and request line.
// Assumes change and sts_clr are single-cycle; a change beats a clear.
module ldm_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic sts_clr,
    input  logic en_wr,
    input  logic en_wdata,
    output logic sts_q,
    output logic en_q,
    output logic irq_n
);
    // Status bit: set on change, cleared by a host read otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (change) begin
            sts_q <= 1'b1;
        end else if (sts_clr) begin
            sts_q <= 1'b0;
        end
    end

    // Interrupt enable, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    // Active-low request from the enabled pending bit.
    assign irq_n = ~(sts_q & en_q);
endmodule

// File: rtl/ldm_reg_port.sv
// Module: address decode and read multiplexer for the host register port.
// Assumes reads are combinational on the address; reg_rd only matters for
// the clear-on-read side effect.
module ldm_reg_port
    import ldm_pkg::*;
(
    input  logic [LDM_ADDR_W-1:0] reg_addr,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [LDM_DATA_W-1:0] reg_wdata,
    input  logic                  defect,
    input  logic                  sts,
    input  logic                  en,
    output logic [LDM_DATA_W-1:0] reg_rdata,
    output logic                  sts_clr,
    output logic                  en_wr,
    output logic                  en_wdata
);
    ldm_reg_e sel;
    assign sel = ldm_reg_e'(reg_addr);

    // Read multiplexer; unused bits stay zero.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_ALARM:   reg_rdata[0] = defect;
            REG_IRQ_STS: reg_rdata[0] = sts;
            REG_IRQ_EN:  reg_rdata[0] = en;
            default:     reg_rdata    = '0;
        endcase
    end

    // Side-effect strobes toward the interrupt controller.
    assign sts_clr  = reg_rd && (sel == REG_IRQ_STS);
    assign en_wr    = reg_wr && (sel == REG_IRQ_EN);
    assign en_wdata = reg_wdata[0];
endmodule

// File: rtl/line_drive_monitor.sv
// Module: top of the line drive pulse activity monitor. Declares a defect
// after THRESH pulse-free bit periods, clears it on any pulse, and reports
// through a clear-on-read status bit and an active-low request line.
// Assumes a single clock domain; pulse inputs are already synchronous.
module line_drive_monitor
    import ldm_pkg::*;
#(
    parameter int THRESH = 128,
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  pulse_pos,
    input  logic                  pulse_neg,
    input  logic [LDM_ADDR_W-1:0] reg_addr,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [LDM_DATA_W-1:0] reg_wdata,
    output logic [LDM_DATA_W-1:0] reg_rdata,
    output logic                  irq_n
);
    logic             pulse_any;
    logic             defect_q;
    logic [CNT_W-1:0] cnt_q;
    logic             change;
    logic             sts_q;
    logic             en_q;
    logic             sts_clr;
    logic             en_wr;
    logic             en_wdata;

    // Either polarity counts as line activity.
    assign pulse_any = pulse_pos | pulse_neg;

    ldm_pulse_timer #(.THRESH(THRESH)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .pulse_any (pulse_any),
        .defect_q  (defect_q),
        .cnt_q     (cnt_q),
        .change    (change)
    );

    ldm_irq_ctrl irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .change   (change),
        .sts_clr  (sts_clr),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .irq_n    (irq_n)
    );

    ldm_reg_port regs_i (
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .defect    (defect_q),
        .sts       (sts_q),
        .en        (en_q),
        .reg_rdata (reg_rdata),
        .sts_clr   (sts_clr),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata)
    );
endmodule

// File: rtl/ldm_checker.sv
// Module: property checker for line_drive_monitor, attached by bind.
// Assumes the internal names defect_q, cnt_q, sts_q and en_q in the top.
module ldm_checker #(
    parameter int THRESH = 128,
    localparam int CNT_W = $clog2(THRESH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             pulse_pos,
    input logic             pulse_neg,
    input logic [1:0]       reg_addr,
    input logic             reg_rd,
    input logic             irq_n,
    input logic             defect_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             sts_q,
    input logic             en_q
);
    // R1: the last pulse-free period before the threshold declares the defect.
    p_declare_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !pulse_pos && !pulse_neg && cnt_q == CNT_W'(THRESH - 1)) |=> defect_q);

    // R2: idle cycles leave count and defect untouched.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(defect_q) && $stable(cnt_q)));

    // R3: a pulse in a bit period clears the defect and the count.
    p_pulse_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (pulse_pos || pulse_neg)) |=> (!defect_q && cnt_q == '0));

    // R4: the count never passes the threshold.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(THRESH));

    // R6: every defect edge leaves the status bit set.
    p_change_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(defect_q) || $fell(defect_q)) |-> sts_q);

    // R7: a status read with no bit period pending clears the bit.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && !bit_en) |=> !sts_q);

    // R9: a low request always has the enable behind it.
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (en_q && sts_q));
endmodule

bind line_drive_monitor ldm_checker #(.THRESH(THRESH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .pulse_pos (pulse_pos),
    .pulse_neg (pulse_neg),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .irq_n     (irq_n),
    .defect_q  (defect_q),
    .cnt_q     (cnt_q),
    .sts_q     (sts_q),
    .en_q      (en_q)
);

// File: tb/line_drive_monitor_tb_top.sv
// Bench: sweeps pulse-free gap lengths, polarities, idle cycles and register
// accesses; a small arithmetic model gives every expected value.
module line_drive_monitor_tb_top;
    localparam int THRESH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       pulse_pos = 1'b0;
    logic       pulse_neg = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int vectors = 0;
    int errors  = 0;

    // Requirement model.
    int   m_cnt = 0;
    logic m_def = 1'b0;
    logic m_sts = 1'b0;
    logic m_en  = 1'b0;

    always #10 clk = ~clk;

    line_drive_monitor #(.THRESH(THRESH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .pulse_pos (pulse_pos),
        .pulse_neg (pulse_neg),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {7'b0, m_def};
            2'd1:    return {7'b0, m_sts};
            2'd2:    return {7'b0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string reg_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R1/R3/R5 alarm";
            2'd1:    return "R6/R7 status";
            2'd2:    return "R9 enable";
            default: return "R10 spare";
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle of stimulus, checked before and after the edge.
    task automatic step(input logic e, input logic p, input logic n,
                        input logic rd, input logic wr, input logic [1:0] a,
                        input logic [7:0] wd);
        logic chg;
        logic nd;
        @(negedge clk);
        bit_en = e; pulse_pos = p; pulse_neg = n;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        check(reg_rdata, exp_read(a), {reg_tag(a), " before edge"});
        @(posedge clk);
        chg = 1'b0;
        nd  = m_def;
        if (e) begin
            if (p || n) begin
                m_cnt = 0;
                nd    = 1'b0;
            end else begin
                if (m_cnt < THRESH) m_cnt++;
                nd = (m_cnt >= THRESH);
            end
            chg   = (nd != m_def);
            m_def = nd;
        end
        if (chg) m_sts = 1'b1;
        else if (rd && a == 2'd1) m_sts = 1'b0;
        if (wr && a == 2'd2) m_en = wd[0];
        #1;
        check(reg_rdata, exp_read(a), {reg_tag(a), " after edge"});
        check({7'b0, irq_n}, {7'b0, ~(m_sts & m_en)}, "R9 irq_n");
    endtask

    task automatic idle_read(input logic [1:0] a);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, d);
    endtask

    task automatic silent(input int periods, input logic [1:0] a);
        for (int k = 0; k < periods; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state seen at the ports.
        check({7'b0, irq_n}, 8'h01, "R10 irq_n in reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) idle_read(2'(a));

        // R9: enable the request line.
        write_reg(2'd2, 8'hFF);
        idle_read(2'd2);

        // R1 R2 R3: gap sweep, rotating polarity, with idle cycles mixed in.
        for (int g = 0; g <= 140; g += (g < 120 ? 20 : 1)) begin
            step(1'b1, (g % 3) != 1, (g % 3) != 0, 1'b0, 1'b0, 2'd0, 8'h00);
            for (int k = 0; k < g; k++) begin
                if (k % 4 == 2) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
                step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
            end
            idle_read(2'd1);
            idle_read(2'd1);
        end

        // R4: long silence saturates and raises no further events.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        idle_read(2'd1);
        silent(300, 2'd0);
        idle_read(2'd1);
        silent(50, 2'd1);

        // R8: clear event in the same cycle as a status read.
        idle_read(2'd1);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 8'h00);
        idle_read(2'd1);
        idle_read(2'd1);

        // R9: a status event with the enable off keeps the line high.
        write_reg(2'd2, 8'h00);
        silent(THRESH, 2'd1);
        idle_read(2'd0);
        write_reg(2'd2, 8'h01);
        idle_read(2'd1);
        idle_read(2'd1);

        // R5 R6: writes to alarm and status registers are ignored.
        write_reg(2'd0, 8'hFF);
        idle_read(2'd0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        write_reg(2'd1, 8'h00);
        idle_read(2'd1);
        write_reg(2'd1, 8'hFF);
        idle_read(2'd1);
        idle_read(2'd1);
        write_reg(2'd3, 8'hFF);
        idle_read(2'd3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule